// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Controller

This block sits between a synchronous host and an external static RAM that has no clock. It stores 2^18 bytes. The host issues one read or one write at a time through a valid/ready handshake. The controller registers the request, then drives the memory pins through a fixed series of phases. Each phase lasts a whole number of clock cycles. The bus is never contested, and the memory's minimum pulse widths and access times are always met.

The memory is selected only while its low-active select is low and its high-active select is high. Both selects move together. Between transfers the device rests in standby. Phase lengths are derived when the block is elaborated. Each nanosecond minimum of the chosen speed grade is divided by the clock period and rounded up, with a floor of one cycle. Read data returns through a registered byte with a one-clock valid strobe. The data bus is split into an output value, an output enable for the tri-state pad and an input value.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it: `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `req_ready`=1, `rd_valid`=0.
- R2: During every read or write phase `mem_ce_n` is 0 and `mem_ce` is 1. In idle both are in their inactive level (1 and 0).
- R3: A read holds select active, `mem_oe_n`=0, `mem_we_n`=1 and the driver off for RD cycles. RD = ceil(max(cycle time, address access, output-enable access) / period), at least 1.
- R4: `rd_data` takes the value on `mem_dq_in` during the last read cycle. `rd_valid` is 1 for exactly one clock, the first cycle after the read phase.
- R5: A write holds `mem_we_n`=0 for WP cycles. WP = ceil(max(write pulse, address-to-end-of-write, data setup) / period), at least 1. `mem_oe_n` stays 1 for the whole write.
- R6: After the write pulse comes a recovery phase of max(1, WC - WP) cycles. In it `mem_we_n`=1 and select stays active. WC = ceil(write cycle / period), so the whole write lasts at least WC cycles.
- R7: `mem_dq_oe` is 1 exactly during the write pulse and recovery, and never while `mem_oe_n` is 0. Throughout, `mem_dq_out` equals the accepted write byte.
- R8: After each read comes a turnaround of TA = ceil(bus release time / period) cycles. In it the memory is deselected with `mem_oe_n`=1, and the controller does not drive the bus.
- R9: `req_ready` is 1 only in idle. A request is taken on a clock edge with `req_valid` and `req_ready` both 1. Address and write data are registered then, so later changes on the request inputs do not affect the transfer in progress. Busy time is WP+REC for a write and RD+TA for a read.
- R10: `SPEED_GRADE` 0, 1 and 2 select the 55, 70 and 100 ns tables. At a 10 ns period, grade 2 gives RD=10, TA=4, WP=8 and a recovery of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rd_data | output | DATA_W | Registered read byte |
| rd_valid | output | 1 | One-clock strobe for `rd_data` |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Low-active select |
| mem_ce | output | 1 | High-active select |
| mem_we_n | output | 1 | Low-active write enable |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_dq_out | output | DATA_W | Value for the data pad driver |
| mem_dq_oe | output | 1 | Enable for the data pad driver |
| mem_dq_in | input | DATA_W | Value seen on the data pins |

## Verification
Writes and reads cover the lowest address, the highest address and a mixed address. The data bytes are all-ones, alternating and mixed. Reading back from separate locations distinguishes a correct address path from one that aliases.

The memory model offers valid data only once output enable has been low for the full read length, so a shortened read phase returns a marker byte instead. After each transfer is accepted, the request inputs are scrambled; this separates registered request capture from a pass-through path. A second instance at the slowest grade shows whether the phase lengths actually follow the grade parameter.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_RD_TURN,
      ST_WR_PULSE,
      ST_WR_REC
   } seq_state_t;

   // nanosecond minima (or maxima for access/release) of one speed grade
   typedef struct packed {
      int unsigned rd_cycle;
      int unsigned addr_acc;
      int unsigned oe_acc;
      int unsigned wr_cycle;
      int unsigned wr_pulse;
      int unsigned addr_to_end;
      int unsigned data_setup;
      int unsigned bus_release;
   } grade_ns_t;

   function automatic grade_ns_t grade_table(input int unsigned grade);
      grade_ns_t g;
      case (grade)
         1:       g = '{70, 70, 35, 70, 55, 60, 30, 25};
         2:       g = '{100, 100, 50, 100, 70, 80, 40, 35};
         default: g = '{55, 55, 30, 55, 45, 50, 25, 20};
      endcase
      return g;
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   // ceiling division with a floor of one cycle
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
      int unsigned c;
      c = (ns + per - 1) / per;
      return (c == 0) ? 1 : c;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_io_regs.sv
module sram_io_regs #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q   <= '0;
         wdata_q  <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture) begin
            rd_data <= mem_dq_in;
         end
         rd_valid <= capture;
      end
   end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W        = 18,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 10,
   parameter int SPEED_GRADE   = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_ce,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam grade_ns_t   G       = grade_table(SPEED_GRADE);
   localparam int unsigned PER     = CLK_PERIOD_NS;
   localparam int unsigned RD_CYC  = ns_to_cyc(max3(G.rd_cycle, G.addr_acc, G.oe_acc), PER);
   localparam int unsigned WP_CYC  = ns_to_cyc(max3(G.wr_pulse, G.addr_to_end, G.data_setup), PER);
   localparam int unsigned WC_CYC  = ns_to_cyc(G.wr_cycle, PER);
   localparam int unsigned REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
   localparam int unsigned TA_CYC  = ns_to_cyc(G.bus_release, PER);
   localparam int unsigned MAX_CYC = max3(max3(RD_CYC, WP_CYC, REC_CYC), TA_CYC, 1);
   localparam int          CNT_W   = $clog2(MAX_CYC + 1);

   localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);
   localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_CYC - 1);

   initial begin : p_param_chk
      assert (SPEED_GRADE >= 0 && SPEED_GRADE <= 2)
         else $error("SPEED_GRADE must be 0, 1 or 2");
      assert (CLK_PERIOD_NS > 0) else $error("CLK_PERIOD_NS must be positive");
      assert (ADDR_W > 0 && DATA_W > 0) else $error("widths must be positive");
   end

   seq_state_t       state_q, state_d;
   logic             accept;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   logic             capture;
   logic             selected;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (accept) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  state_d = ST_WR_PULSE;
                  tmr_val = WP_LD;
               end else begin
                  state_d = ST_RD;
                  tmr_val = RD_LD;
               end
            end
         end
         ST_RD: begin
            if (tmr_expired) begin
               capture  = 1'b1;
               state_d  = ST_RD_TURN;
               tmr_load = 1'b1;
               tmr_val  = TA_LD;
            end
         end
         ST_RD_TURN: begin
            if (tmr_expired) state_d = ST_IDLE;
         end
         ST_WR_PULSE: begin
            if (tmr_expired) begin
               state_d  = ST_WR_REC;
               tmr_load = 1'b1;
               tmr_val  = REC_LD;
            end
         end
         ST_WR_REC: begin
            if (tmr_expired) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sram_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .capture   (capture),
      .mem_dq_in (mem_dq_in),
      .addr_q    (mem_addr),
      .wdata_q   (mem_dq_out),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

   // pin levels decoded from the registered phase
   assign selected  = (state_q == ST_RD) || (state_q == ST_WR_PULSE) || (state_q == ST_WR_REC);
   assign mem_ce_n  = !selected;
   assign mem_ce    = selected;
   assign mem_oe_n  = (state_q != ST_RD);
   assign mem_we_n  = (state_q != ST_WR_PULSE);
   assign mem_dq_oe = (state_q == ST_WR_PULSE) || (state_q == ST_WR_REC);

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_ce,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);

   AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      !mem_oe_n |-> !mem_dq_oe); // R7
   AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> mem_oe_n); // R5
   AST_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> (!mem_ce_n && mem_ce)); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe)); // R9
   AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      rd_valid |=> !rd_valid); // R4
   AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> ($past(!mem_oe_n) && mem_oe_n)); // R4
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
      (!req_ready && $past(!req_ready)) |-> $stable(mem_addr)); // R9
   AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R7
   AST_WE_RISE_SELECTED: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> (!mem_ce_n && mem_ce && mem_dq_oe)); // R6
   AST_PULSE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
      $fell(mem_we_n) |-> mem_dq_oe); // R7

endmodule

bind sram_seq_ctrl sram_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_ce     (mem_ce),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sram_seq_ctrl;

   localparam int T = 10;

   function automatic int cdiv(input int ns);
      int c;
      c = (ns + T - 1) / T;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   // grade 0 expectations
   localparam int RD0  = cdiv(mx(55, 55, 30));
   localparam int WP0  = cdiv(mx(45, 50, 25));
   localparam int WC0  = cdiv(55);
   localparam int REC0 = (WC0 > WP0) ? WC0 - WP0 : 1;
   localparam int TA0  = cdiv(20);
   // grade 2 expectations
   localparam int RD2  = cdiv(mx(100, 100, 50));
   localparam int WP2  = cdiv(mx(70, 80, 40));
   localparam int WC2  = cdiv(100);
   localparam int REC2 = (WC2 > WP2) ? WC2 - WP2 : 1;
   localparam int TA2  = cdiv(35);

   logic        clk, rst;
   logic        req_valid, req_write;
   logic [17:0] req_addr;
   logic [7:0]  req_wdata;
   logic        req_ready, rd_valid;
   logic [7:0]  rd_data;
   logic [17:0] addr;
   logic        ce_n, ce, we_n, oe_n, dq_oe;
   logic [7:0]  dq_out, dq_in;

   logic        b_valid, b_write, b_ready, b_rvalid;
   logic [17:0] b_addr_in, b_addr;
   logic [7:0]  b_wdata, b_rdata, b_dq_out;
   logic        b_ce_n, b_ce, b_we_n, b_oe_n, b_dq_oe;

   int checks = 0;
   int errors = 0;

   initial clk = 1'b0;
   always #(T/2) clk = ~clk;

   sram_seq_ctrl #(.CLK_PERIOD_NS(T), .SPEED_GRADE(0)) u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(addr),
      .mem_ce_n(ce_n), .mem_ce(ce), .mem_we_n(we_n), .mem_oe_n(oe_n),
      .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in));

   sram_seq_ctrl #(.CLK_PERIOD_NS(T), .SPEED_GRADE(2)) u1 (
      .clk(clk), .rst(rst), .req_valid(b_valid), .req_ready(b_ready),
      .req_write(b_write), .req_addr(b_addr_in), .req_wdata(b_wdata),
      .rd_data(b_rdata), .rd_valid(b_rvalid), .mem_addr(b_addr),
      .mem_ce_n(b_ce_n), .mem_ce(b_ce), .mem_we_n(b_we_n), .mem_oe_n(b_oe_n),
      .mem_dq_out(b_dq_out), .mem_dq_oe(b_dq_oe), .mem_dq_in(8'h3C));

   // memory model for u0: valid data only after a full read length
   logic [7:0] bmem [0:63];
   int oe_run;
   int gap;
   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 64; i++) bmem[i] <= 8'h00;
         oe_run <= 0;
         gap    <= 0;
      end else begin
         if (!ce_n && ce && !oe_n) oe_run <= oe_run + 1;
         else                      oe_run <= 0;
         if (!oe_n) gap <= 0;
         else       gap <= gap + 1;
         if (!ce_n && ce && !we_n && dq_oe) bmem[addr[5:0]] <= dq_out;
      end
   end
   assign dq_in = (!ce_n && ce && !oe_n && we_n && oe_run >= RD0 - 1) ? bmem[addr[5:0]] : 8'hEE;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      chk(req_ready === 1'b1, {req, " ready in idle"}, req_ready, 1);
      chk(ce_n === 1'b1 && ce === 1'b0, {req, " deselected in idle"}, {ce_n, ce}, 2'b10);
      chk(we_n === 1'b1 && oe_n === 1'b1 && dq_oe === 1'b0, {req, " strobes idle"},
          {we_n, oe_n, dq_oe}, 3'b110);
   endtask

   task automatic do_write(input logic [17:0] a, input logic [7:0] d);
      int busy = 0, we_lo = 0, rec = 0, bad_oe = 0, bad_drv = 0, bad_addr = 0;
      int bad_sel = 0, first_gap = -1;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
      while (!req_ready) begin
         busy++;
         if (!we_n) we_lo++;
         else if (dq_oe) rec++;
         if (!oe_n) bad_oe++;
         if (!we_n && !dq_oe) bad_drv++;
         if (dq_oe && dq_out !== d) bad_drv++;
         if (dq_oe && first_gap < 0) first_gap = gap;
         if (addr !== a) bad_addr++;
         if (ce_n || !ce) bad_sel++;
         @(negedge clk);
      end
      chk(we_lo == WP0, "R5 write pulse length", we_lo, WP0);
      chk(bad_oe == 0, "R5 output enable high during write", bad_oe, 0);
      chk(rec == REC0, "R6 recovery length", rec, REC0);
      chk(bad_drv == 0, "R7 driver on with write byte", bad_drv, 0);
      chk(bad_sel == 0, "R2 select active during write", bad_sel, 0);
      chk(bad_addr == 0, "R9 address held after request inputs change", bad_addr, 0);
      chk(busy == WP0 + REC0, "R9 write busy time", busy, WP0 + REC0);
      chk(first_gap >= TA0, "R8 driver waits for bus release", first_gap, TA0);
      check_idle("R2");
   endtask

   task automatic do_read(input logic [17:0] a, input logic [7:0] exp);
      int busy = 0, oe_lo = 0, turn = 0, rv = 0, bad = 0, bad_addr = 0;
      logic [7:0] got = 8'h00;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h77;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_write = 1'b1;
      while (!req_ready) begin
         busy++;
         if (!oe_n) begin
            oe_lo++;
            if (ce_n || !ce || !we_n) bad++;
         end else begin
            turn++;
            if (!ce_n || ce) bad++;
         end
         if (dq_oe) bad++;
         if (addr !== a && !oe_n) bad_addr++;
         if (rd_valid) begin rv++; got = rd_data; end
         @(negedge clk);
      end
      if (rd_valid) rv++;
      chk(oe_lo == RD0, "R3 read phase length", oe_lo, RD0);
      chk(turn == TA0, "R8 turnaround length", turn, TA0);
      chk(bad == 0, "R3 read/turnaround pin levels", bad, 0);
      chk(bad_addr == 0, "R9 read address held", bad_addr, 0);
      chk(rv == 1, "R4 single valid strobe", rv, 1);
      chk(got === exp, "R4 read data", got, exp);
      chk(busy == RD0 + TA0, "R9 read busy time", busy, RD0 + TA0);
      check_idle("R2");
   endtask

   task automatic do_slow(input bit wr);
      int busy = 0, we_lo = 0, rv = 0;
      logic [7:0] got = 8'h00;
      @(negedge clk);
      b_valid = 1'b1; b_write = wr; b_addr_in = 18'h2A5A5; b_wdata = 8'h96;
      @(negedge clk);
      b_valid = 1'b0;
      while (!b_ready) begin
         busy++;
         if (!b_we_n) we_lo++;
         if (b_rvalid) begin rv++; got = b_rdata; end
         @(negedge clk);
      end
      if (wr) begin
         chk(we_lo == WP2, "R10 slow grade write pulse", we_lo, WP2);
         chk(busy == WP2 + REC2, "R10 slow grade write busy", busy, WP2 + REC2);
      end else begin
         chk(busy == RD2 + TA2, "R10 slow grade read busy", busy, RD2 + TA2);
         chk(rv == 1 && got === 8'h3C, "R10 slow grade read data", got, 8'h3C);
      end
   endtask

   initial begin : watchdog
      #(150000 * T);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      rst = 1'b1;
      req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      b_valid = 1'b0; b_write = 1'b0; b_addr_in = '0; b_wdata = '0;
      repeat (3) @(negedge clk);
      chk(ce_n === 1'b1 && ce === 1'b0, "R1 selects inactive in reset", {ce_n, ce}, 2'b10);
      chk(we_n === 1'b1 && oe_n === 1'b1 && dq_oe === 1'b0, "R1 strobes in reset",
          {we_n, oe_n, dq_oe}, 3'b110);
      chk(req_ready === 1'b1 && rd_valid === 1'b0, "R1 host side in reset",
          {req_ready, rd_valid}, 2'b10);
      rst = 1'b0;
      @(negedge clk);
      check_idle("R1");

      do_write(18'h00000, 8'hA5);
      do_write(18'h3FFFF, 8'hFF);
      do_write(18'h15555, 8'h5A);
      do_read(18'h00000, 8'hA5);
      do_read(18'h3FFFF, 8'hFF);
      do_read(18'h15555, 8'h5A);
      do_write(18'h00000, 8'h3C);   // write right after a read: bus release
      do_read(18'h00000, 8'h3C);
      do_read(18'h3FFFF, 8'hFF);

      do_slow(1'b1);
      do_slow(1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule